// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block computes the program counter of a single-issue microcontroller in which every change of flow has one delay slot. On each step it receives the decoded control fields of the current instruction. These are a branch kind, the source register value, an immediate (which doubles as a bit index), a signed relative offset, an absolute call target, and call, return, wait-for-input and repeat flags. A taken branch, a call or a return records a pending target. The next instruction still executes, and the program counter jumps to the target after it. Calls save their return address on a small internal stack.

A wait-for-input instruction arms packet dispatch. The step after it supplies the packet header held in register 1. The sequencer decodes the header, loads the remaining-count register with the packet length, and jumps through a jump table that is indexed by the packet opcode. A separate port writes the jump table. Instructions marked as repeating hold the program counter and count the remaining-count register down. They are skipped entirely when the count is already zero.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, `pc_o` is RESET_PC (0), `rem_o` is 0, `pend_o` is low and all four error flags are low.
- R2: A step with no pending target, no dispatch and no repeat hold advances `pc_o` by one. A cycle without `step_i` leaves `pc_o` and `rem_o` unchanged.
- R3: The `br_kind_i` encoding is as follows. 1 is taken when `src_i` differs from the zero-extended `imm_i`. 2 is taken when they are equal. 3 is taken when bit `imm_i[4:0]` of `src_i` is 0. 4 is taken when that bit is 1. 0 means no branch. The target is the branch's own PC plus the sign-extended `off_i`.
- R4: A taken branch raises `pend_o`. The following step (the delay slot) advances to PC+1, and the step after that loads the target.
- R5: A call pushes its own PC+2 and makes `call_tgt_i` pending. A return pops the top entry into the pending target and also has a delay slot. If several flags are set, return wins over call, and call wins over branch.
- R6: A call with STACK_DEPTH entries already stored sets `ovf_o`, drops the push and keeps the existing entries. A return on an empty stack sets `unf_o` and makes nothing pending. Both flags stay set until reset.
- R7: A wait-for-input issued while a target is pending sets `win_err_o` and is ignored, so no dispatch follows.
- R8: On the step after an accepted wait-for-input, the pending target is ignored. `pc_o` is loaded from the jump table and `rem_o` from the header count.
- R9: A header with bits 31:28 equal to 4 has its count in bits 6:0 and uses jump-table slot T4_SLOT (127). During that step, `r1_we_o` is high and `r1_wdata_o` is the header with bits 31:28 cleared.
- R10: A header with bits 31:28 equal to 7 has its opcode in bits 22:16 as the table index and its count in bits 13:0. `r1_we_o` stays low. Any other header sets `bad_pkt_o` (sticky), and the step proceeds as an ordinary one.
- R11: With `rep_i` set and `rem_o` above 1, the PC holds and `rem_o` decrements. With `rem_o` equal to 1, `rem_o` becomes 0 and the PC advances. With `rem_o` equal to 0, `exec_o` is low, the PC advances and the instruction's control fields have no effect.
- R12: A `jt_we_i` cycle writes `jt_data_i` into entry `jt_addr_i`, and later dispatches use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| step_i | input | 1 | An instruction is stepped this cycle |
| rep_i | input | 1 | Instruction carries the repeat bit |
| br_kind_i | input | 3 | Conditional branch kind |
| src_i | input | 32 | Source register value |
| imm_i | input | IMM_W | Immediate or bit index |
| off_i | input | OFF_W | Signed branch offset |
| call_i | input | 1 | Call instruction |
| call_tgt_i | input | PC_W | Absolute call target |
| ret_i | input | 1 | Return instruction |
| win_i | input | 1 | Wait-for-input instruction |
| hdr_i | input | 32 | Register 1 value (packet header) |
| jt_we_i | input | 1 | Jump table write enable |
| jt_addr_i | input | JT_AW | Jump table write index |
| jt_data_i | input | PC_W | Jump table write data |
| pc_o | output | PC_W | Program counter |
| rem_o | output | REM_W | Remaining-count register |
| exec_o | output | 1 | Stepped instruction is executed, not skipped |
| pend_o | output | 1 | A target is pending |
| r1_we_o | output | 1 | Write-back of the masked header to register 1 |
| r1_wdata_o | output | 32 | Masked header |
| ovf_o | output | 1 | Call stack overflow |
| unf_o | output | 1 | Call stack underflow |
| win_err_o | output | 1 | Wait-for-input issued with a target pending |
| bad_pkt_o | output | 1 | Unknown packet header type |

## Verification
The bench builds the sequencer with STACK_DEPTH set to 4 and keeps the other parameters at their defaults. With this depth, a five-call chain reaches the overflow path in a few dozen cycles, and the bench can then confirm that the dropped push did not overwrite the top entry. The default 128-entry table keeps slot 127 as the type-4 slot. Type-7 opcodes 5 and 9 therefore have their own slots, which the bench rewrites to test the write port.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int PC_W        = 12,
  parameter int IMM_W       = 16,
  parameter int OFF_W       = 10,
  parameter int REM_W       = 14,
  parameter int STACK_DEPTH = 8,
  parameter int JT_DEPTH    = 128,
  parameter int T4_SLOT     = 127,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int JT_AW = $clog2(JT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              rep_i,
  input  logic [2:0]        br_kind_i,
  input  logic [31:0]       src_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              call_i,
  input  logic [PC_W-1:0]   call_tgt_i,
  input  logic              ret_i,
  input  logic              win_i,
  input  logic [31:0]       hdr_i,
  input  logic              jt_we_i,
  input  logic [JT_AW-1:0]  jt_addr_i,
  input  logic [PC_W-1:0]   jt_data_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [REM_W-1:0]  rem_o,
  output logic              exec_o,
  output logic              pend_o,
  output logic              r1_we_o,
  output logic [31:0]       r1_wdata_o,
  output logic              ovf_o,
  output logic              unf_o,
  output logic              win_err_o,
  output logic              bad_pkt_o
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);
  localparam int SA_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam logic [PC_W-1:0]  PC_ONE  = 1;
  localparam logic [PC_W-1:0]  PC_TWO  = 2;
  localparam logic [REM_W-1:0] REM_ONE = 1;
  localparam logic [SP_W-1:0]  SP_ONE  = 1;
  localparam logic [SP_W-1:0]  SP_FULL = SP_W'(STACK_DEPTH);

  logic [PC_W-1:0]  pc, pc_n, pend, pend_n;
  logic [REM_W-1:0] rem, rem_n;
  logic [SP_W-1:0]  sp, sp_n;
  logic             waitq, wait_n;
  logic [PC_W-1:0]  stk [STACK_DEPTH];
  logic [PC_W-1:0]  jt  [JT_DEPTH];
  logic [SA_W-1:0]  top_idx, push_idx;
  logic push, ovf_set, unf_set, werr_set, bad_set, r1_we;
  logic take, hold, ex, is_t4, is_t7;

  assign top_idx  = SA_W'(sp - SP_ONE);
  assign push_idx = SA_W'(sp);
  assign hold  = step_i && rep_i && (rem > REM_ONE);
  assign ex    = !(rep_i && rem == '0);
  assign is_t4 = hdr_i[31:28] == 4'h4;
  assign is_t7 = hdr_i[31:28] == 4'h7;

  always_comb begin
    unique case (br_kind_i)
      3'd1:    take = src_i != 32'(imm_i);
      3'd2:    take = src_i == 32'(imm_i);
      3'd3:    take = !src_i[imm_i[4:0]];
      3'd4:    take = src_i[imm_i[4:0]];
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    pc_n = pc; pend_n = pend; wait_n = waitq; rem_n = rem; sp_n = sp;
    push = 1'b0; ovf_set = 1'b0; unf_set = 1'b0; werr_set = 1'b0;
    bad_set = 1'b0; r1_we = 1'b0;
    if (step_i) begin
      if (hold) begin
        rem_n = rem - REM_ONE;
      end else begin
        if (rep_i && rem != '0) rem_n = rem - REM_ONE;
        pc_n   = (pend != '0) ? pend : pc + PC_ONE;
        pend_n = '0;
        wait_n = 1'b0;
        if (ex) begin
          if (ret_i) begin
            if (sp == '0) unf_set = 1'b1;
            else begin
              pend_n = stk[top_idx];
              sp_n   = sp - SP_ONE;
            end
          end else if (call_i) begin
            pend_n = call_tgt_i;
            if (sp == SP_FULL) ovf_set = 1'b1;
            else begin
              push = 1'b1;
              sp_n = sp + SP_ONE;
            end
          end else if (take) begin
            pend_n = pc + PC_W'($signed(off_i));
          end
          if (win_i) begin
            if (pend != '0) werr_set = 1'b1;
            else wait_n = 1'b1;
          end
        end
        if (waitq) begin
          if (is_t4) begin
            pc_n  = jt[JT_AW'(T4_SLOT)];
            rem_n = REM_W'(hdr_i[6:0]);
            r1_we = 1'b1;
          end else if (is_t7) begin
            pc_n  = jt[hdr_i[16 +: JT_AW]];
            rem_n = REM_W'(hdr_i[13:0]);
          end else begin
            bad_set = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= RESET_PC; pend <= '0; rem <= '0; sp <= '0; waitq <= 1'b0;
      ovf_o <= 1'b0; unf_o <= 1'b0; win_err_o <= 1'b0; bad_pkt_o <= 1'b0;
    end else begin
      pc <= pc_n; pend <= pend_n; rem <= rem_n; sp <= sp_n; waitq <= wait_n;
      ovf_o     <= ovf_o | ovf_set;
      unf_o     <= unf_o | unf_set;
      win_err_o <= win_err_o | werr_set;
      bad_pkt_o <= bad_pkt_o | bad_set;
    end
  end

  always_ff @(posedge clk) begin
    if (push) stk[push_idx] <= pc + PC_TWO;
    if (jt_we_i) jt[jt_addr_i] <= jt_data_i;
  end

  assign pc_o       = pc;
  assign rem_o      = rem;
  assign exec_o     = step_i && ex;
  assign pend_o     = pend != '0;
  assign r1_we_o    = r1_we;
  assign r1_wdata_o = {4'h0, hdr_i[27:0]};

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(pc) && $stable(rem));
  p_pend_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !hold && !waitq && pend != '0 |=> pc == $past(pend));
  p_sp_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_FULL);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !hold && ex && !ret_i && call_i && sp == SP_FULL |=> ovf_o && sp == SP_FULL);
  p_win_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !hold && ex && win_i && pend != '0 |=> win_err_o && !waitq);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && rep_i && rem > REM_ONE |=> pc == $past(pc) && rem == $past(rem) - REM_ONE);
endmodule

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic step_i, rep_i, call_i, ret_i, win_i, jt_we_i;
  logic [2:0]  br_kind_i;
  logic [31:0] src_i, hdr_i;
  logic [15:0] imm_i;
  logic [9:0]  off_i;
  logic [11:0] call_tgt_i, jt_data_i;
  logic [6:0]  jt_addr_i;
  logic [11:0] pc_o;
  logic [13:0] rem_o;
  logic exec_o, pend_o, r1_we_o, ovf_o, unf_o, win_err_o, bad_pkt_o;
  logic [31:0] r1_wdata_o;

  pc_sequencer #(.STACK_DEPTH(4)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [11:0] pc; logic [13:0] rem; logic [3:0] fl; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  logic [13:0] cur_rem = '0;
  logic [3:0]  cur_fl = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " pc"}, 32'(pc_o), 32'(e.pc));
      chk({e.tag, " rem"}, 32'(rem_o), 32'(e.rem));
      chk({e.tag, " flags"}, 32'({ovf_o, unf_o, win_err_o, bad_pkt_o}), 32'(e.fl));
    end
  end

  task automatic idle();
    step_i = 0; rep_i = 0; call_i = 0; ret_i = 0; win_i = 0; jt_we_i = 0;
    br_kind_i = 0; src_i = 0; hdr_i = 0; imm_i = 0; off_i = 0;
    call_tgt_i = 0; jt_data_i = 0; jt_addr_i = 0;
  endtask

  task automatic go(input logic [11:0] ep, input logic ee, input string tag);
    step_i = 1;
    #1 chk({tag, " exec"}, 32'(exec_o), 32'(ee));
    @(posedge clk);
    q.push_back('{ep, cur_rem, cur_fl, tag});
    @(negedge clk);
    idle();
  endtask

  task automatic jt_wr(input logic [6:0] a, input logic [11:0] d);
    jt_we_i = 1; jt_addr_i = a; jt_data_i = d;
    @(posedge clk);
    q.push_back('{12'h000, cur_rem, cur_fl, "R12 write no step"});
    @(negedge clk);
    idle();
  endtask

  task automatic br(input logic [2:0] k, input logic [31:0] s, input logic [15:0] im,
                    input int off, input logic [11:0] ep, input string tag);
    br_kind_i = k; src_i = s; imm_i = im; off_i = 10'(off);
    go(ep, 1'b1, tag);
  endtask

  task automatic call(input logic [11:0] t, input logic [11:0] ep, input string tag);
    call_i = 1; call_tgt_i = t;
    go(ep, 1'b1, tag);
  endtask

  task automatic ret(input logic [11:0] ep, input string tag);
    ret_i = 1;
    go(ep, 1'b1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R1 pc", 32'(pc_o), 0);
    chk("R1 rem", 32'(rem_o), 0);
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 flags", 32'({ovf_o, unf_o, win_err_o, bad_pkt_o}), 0);

    jt_wr(7'd5, 12'h300);
    jt_wr(7'd127, 12'h400);
    jt_wr(7'd9, 12'h500);

    go(12'd1, 1, "R2 inc");
    go(12'd2, 1, "R2 inc");

    br(3'd1, 32'd5, 16'd3, 10, 12'd3, "R4 delay slot");
    chk("R4 pend", 32'(pend_o), 1);
    go(12'd12, 1, "R4 target");
    br(3'd1, 32'd3, 16'd3, 10, 12'd13, "R3 ne not taken");
    go(12'd14, 1, "R3 no target");
    br(3'd2, 32'd7, 16'd7, -4, 12'd15, "R3 eq taken");
    go(12'd10, 1, "R3 backward");
    br(3'd3, 32'hFFFF_FFEF, 16'd4, 5, 12'd11, "R3 bit clear taken");
    go(12'd15, 1, "R3 bit clear target");
    br(3'd4, 32'hFFFF_FFEF, 16'd4, 5, 12'd16, "R3 bit set not taken");
    br(3'd4, 32'h10, 16'd4, 2, 12'd17, "R3 bit set taken");
    go(12'd18, 1, "R3 bit set target");

    call(12'h100, 12'd19, "R5 call slot");
    go(12'h100, 1, "R5 call target");
    call(12'h200, 12'h101, "R5 nested call slot");
    go(12'h200, 1, "R5 nested target");
    ret(12'h201, "R5 ret slot");
    go(12'h102, 1, "R5 ret to inner");
    ret(12'h103, "R5 ret slot");
    go(12'd20, 1, "R5 ret to outer");

    cur_fl = 4'b0100;
    ret(12'd21, "R6 underflow");
    go(12'd22, 1, "R6 underflow no branch");

    call(12'h040, 12'd23, "R6 fill");  go(12'h040, 1, "R6 fill");
    call(12'h050, 12'h041, "R6 fill"); go(12'h050, 1, "R6 fill");
    call(12'h060, 12'h051, "R6 fill"); go(12'h060, 1, "R6 fill");
    call(12'h070, 12'h061, "R6 fill"); go(12'h070, 1, "R6 fill");
    cur_fl = 4'b1100;
    call(12'h080, 12'h071, "R6 overflow");
    go(12'h080, 1, "R6 overflow target");
    ret(12'h081, "R6 top kept");
    go(12'h062, 1, "R6 top kept");

    br(3'd2, 32'd0, 16'd0, 3, 12'h063, "R7 set pending");
    cur_fl = 4'b1110;
    win_i = 1;
    go(12'h065, 1, "R7 win rejected");
    go(12'h066, 1, "R7 no dispatch");

    win_i = 1;
    go(12'h067, 1, "R8 win");
    hdr_i = 32'h7005_0003; step_i = 1;
    #1 chk("R10 t7 no r1 write", 32'(r1_we_o), 0);
    cur_rem = 14'd3;
    go(12'h300, 1, "R10 t7 dispatch");

    rep_i = 1; cur_rem = 14'd2; go(12'h300, 1, "R11 hold");
    rep_i = 1; cur_rem = 14'd1; go(12'h300, 1, "R11 hold");
    rep_i = 1; cur_rem = 14'd0; go(12'h301, 1, "R11 last");
    rep_i = 1; go(12'h302, 0, "R11 skipped");
    rep_i = 1; br_kind_i = 3'd2; src_i = 0; imm_i = 0; off_i = 10'd8;
    go(12'h303, 0, "R11 skipped branch");
    go(12'h304, 1, "R11 no branch");

    win_i = 1;
    go(12'h305, 1, "R9 win");
    hdr_i = 32'h4ABC_0012; step_i = 1;
    #1 chk("R9 r1 we", 32'(r1_we_o), 1);
    chk("R9 r1 data", r1_wdata_o, 32'h0ABC_0012);
    cur_rem = 14'h12;
    go(12'h400, 1, "R9 t4 dispatch");

    win_i = 1;
    go(12'h401, 1, "R10 win");
    hdr_i = 32'h3000_0000; cur_fl = 4'b1111;
    go(12'h402, 1, "R10 bad header");

    win_i = 1;
    go(12'h403, 1, "R12 win");
    hdr_i = 32'h7009_0000; cur_rem = 14'd0;
    go(12'h500, 1, "R12 slot 9");
    jt_addr_i = 7'd5; jt_data_i = 12'h600; jt_we_i = 1;
    @(posedge clk); @(negedge clk); idle();
    win_i = 1;
    go(12'h501, 1, "R12 win");
    hdr_i = 32'h7005_0002; cur_rem = 14'd2;
    go(12'h600, 1, "R12 rewritten slot");

    @(negedge clk); @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule